// File: doc/BRIEF.md
# Dual 16-bit Down-Counting Timer

This block is a bus-attached peripheral that holds two independent 16-bit down-counting timers, called A and B. Each timer has its own 16-bit interval value, an 8-bit prescaler and a mode field. Bit 0 of the mode field picks between a single run and a free-running repeat. When a timer finishes a count period, it sets its own timeout flag. Timer A's flag is the low byte lane of the status word and timer B's flag is the next byte lane up.

A mask word selects which flags reach the block's two interrupt outputs. There is one output per timer. Software acknowledges an event by writing ones to the clear register.

A register is written on a clock edge where `bus_sel` and `bus_wr` are both high. A register is read on an edge where `bus_sel` is high and `bus_wr` is low. Read data appears on `bus_rdata` after that edge and stays there until the next edge.

Register map (byte offsets):

| Offset | Register |
|--------|----------|
| 0x04 | Timer A mode |
| 0x08 | Timer B mode |
| 0x0C | Control: timer A enable at bit 0, timer B enable at bit 8 |
| 0x18 | Mask |
| 0x1C | Raw status |
| 0x20 | Masked status |
| 0x24 | Clear |
| 0x28 | Timer A load |
| 0x2C | Timer B load |
| 0x38 | Timer A prescale |
| 0x3C | Timer B prescale |

Top module: `dual_timer`

## Requirements
- R1: After reset, every register reads as 0 and both `irq_a` and `irq_b` are low.
- R2: Take the edge at which a write to control sets a timer's enable bit (bit 0 for A, bit 8 for B). The timer sets its raw status flag (bit 0 for A, bit 8 for B) on the L×(P+1)-th edge after that edge. Here L is the load value and P is the prescale value.
- R3: With mode bit 0 clear, a timeout reloads the counter from the load value and counting goes on. The next flag is set L×(P+1) edges later, and the enable bit stays 1.
- R4: With mode bit 0 set, a timeout clears that timer's enable bit in control and the timer stops. No further flag is set until the timer is enabled again.
- R5: A write to the mask register keeps only the bits in 0x0707. Every other mask bit reads back as 0.
- R6: `irq_a` is high exactly when the raw status bits 3:0 ANDed with the mask are not all zero. `irq_b` does the same using bits 11:8. The two outputs do not affect each other.
- R7: A write to the clear register clears each raw status bit whose written bit is 1 and leaves the others unchanged. The interrupt output falls after that same edge.
- R8: The load registers keep only the low 16 bits of a write. The prescale registers keep only the low 8 bits.
- R9: Raw status reads at 0x1C. Raw status ANDed with the mask reads at 0x20.
- R10: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.
- R11: When an enable bit goes from 0 to 1, the counter restarts from the load value and the prescaler restarts from 0. Any count left over from an earlier run is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_a | output | 1 | Timer A interrupt |
| irq_b | output | 1 | Timer B interrupt |

## Verification
A timeout flag and its interrupt appear on the L×(P+1)-th clock edge after the enable write edge. The bench counts falling edges from the return of the enable write. It checks the interrupt one cycle before that edge, where it must be low, and right after it, where it must be high.

A clear or mask write changes the interrupt right after its own edge, and the bench samples at the next falling edge. Read data is due one edge after the read strobe. The monitor pops the expected word at the falling edge that follows the read edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int NTMR   = 2;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int MODE_W = 4;
    localparam int LANE_W = 8;
    localparam int IRQ_W  = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_MODE_A = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MODE_B = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_LOAD_A = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOAD_B = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_PRE_A  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_PRE_B  = 8'h3C;

    localparam logic [DATA_W-1:0] MASK_KEEP = 32'h0000_0707;

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [PRE_W-1:0] prescale;
        logic             oneshot;
    } tmr_cfg_t;

    function automatic logic [ADDR_W-1:0] ofs_load(int n);
        return (n == 0) ? OFS_LOAD_A : OFS_LOAD_B;
    endfunction

    function automatic logic [ADDR_W-1:0] ofs_pre(int n);
        return (n == 0) ? OFS_PRE_A : OFS_PRE_B;
    endfunction

    function automatic logic [ADDR_W-1:0] ofs_mode(int n);
        return (n == 0) ? OFS_MODE_A : OFS_MODE_B;
    endfunction

endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter
    import dtmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     run,
    input  tmr_cfg_t cfg,
    output logic     timeout
);

    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             tick;
    logic             last;

    assign tick    = run && (pre_q >= cfg.prescale);
    assign last    = (cnt_q <= CNT_W'(1));
    assign timeout = tick && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (start) begin
            cnt_q <= cfg.load;
            pre_q <= '0;
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                cnt_q <= last ? cfg.load : cnt_q - CNT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    // R11: a restart takes the load value and zeroes the prescaler
    p_start_load_r11: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == $past(cfg.load) && pre_q == '0));

    // R3: the counter reloads after a timeout
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (timeout && !start) |=> (cnt_q == $past(cfg.load)));

endmodule

// File: rtl/dtmr_status.sv
module dtmr_status
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NTMR-1:0]   timeout,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] mask,
    output logic [NTMR-1:0]   irq
);

    logic [DATA_W-1:0] raw_q, raw_d, mask_q;

    always_comb begin
        raw_d = raw_q;
        if (clr_we) raw_d = raw_d & ~wdata;
        for (int n = 0; n < NTMR; n++) begin
            if (timeout[n]) raw_d[n*LANE_W] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= raw_d;
            if (mask_we) mask_q <= wdata & MASK_KEEP;
        end
    end

    assign raw  = raw_q;
    assign mask = mask_q;

    for (genvar n = 0; n < NTMR; n++) begin : g_lane
        localparam int B = n * LANE_W;
        assign irq[n] = |(raw_q[B +: IRQ_W] & mask_q[B +: IRQ_W]);

        // R2: a timeout leaves its flag set
        p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
            timeout[n] |=> raw_q[B]);

        // R7: a written one clears the flag unless a new timeout arrives
        p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
            (clr_we && wdata[B] && !timeout[n]) |=> !raw_q[B]);
    end

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_a,
    output logic              irq_b
);

    logic              wr_en, rd_en;
    logic              ctrl_we, mask_we, clr_we;
    logic [NTMR-1:0]   en_q, start, tmo, irq_w;
    tmr_cfg_t          cfg    [NTMR];
    logic [MODE_W-1:0] mode_q [NTMR];
    logic [DATA_W-1:0] raw_w, mask_w, rd_mux, rd_q;

    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && !bus_wr;
    assign ctrl_we = wr_en && (bus_addr == OFS_CTRL);
    assign mask_we = wr_en && (bus_addr == OFS_MASK);
    assign clr_we  = wr_en && (bus_addr == OFS_CLR);

    for (genvar n = 0; n < NTMR; n++) begin : g_tmr
        localparam int EB = n * LANE_W;
        logic [CNT_W-1:0]  load_r;
        logic [PRE_W-1:0]  pre_r;
        logic [MODE_W-1:0] mode_r;
        logic              en_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                load_r <= '0;
                pre_r  <= '0;
                mode_r <= '0;
            end else if (wr_en) begin
                if (bus_addr == ofs_load(n)) load_r <= bus_wdata[CNT_W-1:0];
                if (bus_addr == ofs_pre(n))  pre_r  <= bus_wdata[PRE_W-1:0];
                if (bus_addr == ofs_mode(n)) mode_r <= bus_wdata[MODE_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst)                        en_r <= 1'b0;
            else if (ctrl_we)               en_r <= bus_wdata[EB];
            else if (tmo[n] && mode_r[0])   en_r <= 1'b0;
        end

        assign en_q[n]   = en_r;
        assign start[n]  = ctrl_we && bus_wdata[EB] && !en_r;
        assign mode_q[n] = mode_r;
        assign cfg[n]    = '{load: load_r, prescale: pre_r, oneshot: mode_r[0]};

        dtmr_counter u_cnt (
            .clk     (clk),
            .rst     (rst),
            .start   (start[n]),
            .run     (en_r),
            .cfg     (cfg[n]),
            .timeout (tmo[n])
        );

        // R4: a single-run timeout drops the enable bit
        p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
            (tmo[n] && mode_r[0] && !ctrl_we) |=> !en_r);
    end

    dtmr_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .timeout (tmo),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wdata   (bus_wdata),
        .raw     (raw_w),
        .mask    (mask_w),
        .irq     (irq_w)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_CTRL: begin
                for (int n = 0; n < NTMR; n++) rd_mux[n*LANE_W] = en_q[n];
            end
            OFS_MASK:  rd_mux = mask_w;
            OFS_RAW:   rd_mux = raw_w;
            OFS_MSTAT: rd_mux = raw_w & mask_w;
            default: begin
                for (int n = 0; n < NTMR; n++) begin
                    if (bus_addr == ofs_load(n)) rd_mux = DATA_W'(cfg[n].load);
                    if (bus_addr == ofs_pre(n))  rd_mux = DATA_W'(cfg[n].prescale);
                    if (bus_addr == ofs_mode(n)) rd_mux = DATA_W'(mode_q[n]);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
        else            rd_q <= '0;
    end

    assign bus_rdata = rd_q;
    assign irq_a     = irq_w[0];
    assign irq_b     = irq_w[1];

    // R10: reading an unmapped offset returns zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_addr == 8'h40) |=> (bus_rdata == '0));

endmodule

// File: tb/sim_dual_timer.sv
`timescale 1ns/1ps
module sim_dual_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_a, irq_b;

    int n_chk = 0;
    int n_bad = 0;
    logic pend = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    dual_timer u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always @(posedge clk) pend <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        item_t it;
        if (pend) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: read with no expected item");
            end else begin
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%02h actual=%08h expected=%08h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // R1 reset state
        chk(irq_a, 1'b0, "R1 irq_a");
        chk(irq_b, 1'b0, "R1 irq_b");
        rd(8'h0C, 32'h0, "R1 ctrl");
        rd(8'h18, 32'h0, "R1 mask");
        rd(8'h1C, 32'h0, "R1 raw");
        rd(8'h28, 32'h0, "R1 loadA");

        // R5 mask width
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0000_0707, "R5 mask keep");
        wr(8'h18, 32'h0000_0101);

        // R8 field widths, timer A periodic L=5 P=2
        wr(8'h28, 32'hABCD_0005);
        rd(8'h28, 32'h0000_0005, "R8 loadA");
        wr(8'h38, 32'h0000_0102);
        rd(8'h38, 32'h0000_0002, "R8 preA");
        wr(8'h04, 32'h0);

        wr(8'h0C, 32'h1);
        wait_n(14);
        chk(irq_a, 1'b0, "R2 A before period");
        wait_n(1);
        chk(irq_a, 1'b1, "R2 A at period");
        chk(irq_b, 1'b0, "R6 B stays low");
        wr(8'h24, 32'h1);
        chk(irq_a, 1'b0, "R7 clear drops irq_a");
        wait_n(13);
        chk(irq_a, 1'b0, "R3 A before second period");
        wait_n(1);
        chk(irq_a, 1'b1, "R3 A second period");
        rd(8'h0C, 32'h1, "R3 enable kept");
        wr(8'h0C, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h0, "R7 clear all");

        // R4 timer B single run, L=3 P=1
        wr(8'h08, 32'h1);
        wr(8'h2C, 32'h0001_0003);
        rd(8'h2C, 32'h0000_0003, "R8 loadB");
        wr(8'h3C, 32'h0000_01FF);
        rd(8'h3C, 32'h0000_00FF, "R8 preB");
        wr(8'h3C, 32'h1);
        wr(8'h0C, 32'h100);
        wait_n(5);
        chk(irq_b, 1'b0, "R2 B before period");
        wait_n(1);
        chk(irq_b, 1'b1, "R2 B at period");
        chk(irq_a, 1'b0, "R6 A stays low");
        rd(8'h0C, 32'h0, "R4 enable cleared");

        // R6 and R9 masking
        wr(8'h18, 32'h0000_0001);
        chk(irq_b, 1'b0, "R6 B masked off");
        rd(8'h20, 32'h0, "R9 masked status");
        rd(8'h1C, 32'h100, "R9 raw status");
        wr(8'h18, 32'h0000_0100);
        rd(8'h20, 32'h100, "R9 masked status B");

        // R7 selective clear
        wr(8'h24, 32'h1);
        rd(8'h1C, 32'h100, "R7 unwritten bit kept");
        wr(8'h24, 32'h100);
        rd(8'h1C, 32'h0, "R7 written bit cleared");
        wait_n(20);
        rd(8'h1C, 32'h0, "R4 no further timeout");

        // R10 unmapped offsets
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, 32'h0, "R10 unmapped read");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R10 ctrl untouched");
        rd(8'h18, 32'h100, "R10 mask untouched");

        // R11 restart after partial run, L=4 P=0
        wr(8'h28, 32'h4);
        wr(8'h38, 32'h0);
        wr(8'h18, 32'h1);
        wr(8'h0C, 32'h1);
        wait_n(2);
        wr(8'h0C, 32'h0);
        wr(8'h24, 32'hFFFF);
        wr(8'h0C, 32'h1);
        wait_n(3);
        chk(irq_a, 1'b0, "R11 no early timeout");
        wait_n(1);
        chk(irq_a, 1'b1, "R11 full period after restart");
        wr(8'h0C, 32'h0);

        wait_n(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule